// File: doc/BRIEF.md
# I2C EEPROM Target With Page Write

This block is an I2C target that fronts a 256-byte memory array held in registers. It watches SCL and SDA, which the system clock oversamples, and detects start and stop conditions. It answers to one fixed 7-bit device address and keeps an 8-bit word pointer. A master can write single bytes, write pages of up to 16 bytes, and read bytes one after another.

Written bytes first collect in a one-page staging buffer. They reach the array in one cycle, and only when a stop condition closes the transfer. Two inputs can block that step: a write-protect pin and a supply-low flag from a voltage supervisor. After a real commit, a programming-busy window of `BUSY_CYCLES` clocks begins. During that window the target does not acknowledge its own address.

SDA is modelled as open drain. The block never drives the line high. It only asserts `sda_oe` to pull the line low, for acknowledges and for read data bits.

Top module: `i2c_page_eeprom`

## Requirements
- R1: The target acknowledges only when the 7 upper bits of the first byte after a start equal `DEV_ADDR`. Bit 0 selects the direction (0 = write, 1 = read). For any other address the target leaves SDA released for the rest of the transfer.
- R2: A write transfer carries the device address, then a word-address byte, then a data byte, then a stop. Afterwards, reading that word address returns the data byte.
- R3: In a write transfer, each data byte goes to the current word pointer and then the low 4 pointer bits increment. They wrap inside the 16-byte page and the upper 4 bits stay fixed, so a 17th byte overwrites the first slot.
- R4: Buffered bytes reach the array only at a stop. A repeated start before the stop discards them: the array is unchanged and no busy window starts.
- R5: While `wp_i` is high at the stop, the target still acknowledges address and data bytes. It leaves the array unchanged and starts no busy window.
- R6: While `supply_low_i` is high at the stop, writing is blocked in the same way as R5.
- R7: After a committed write, the target ignores its own address for `BUSY_CYCLES` clocks. Once that window is over, it acknowledges again.
- R8: After each byte the master acknowledges, a read advances the pointer through all 256 bytes, wrapping from 255 to 0. A master NACK ends the read.
- R9: A write that sends only a word address, followed by a repeated start and a read, returns the byte at that address.
- R10: `sda_oe` = 1 pulls SDA low. It changes only while SCL is low.
- R11: Reset releases SDA, returns the target to idle and clears the whole array to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low |
| wp_i | input | 1 | Write protect, high blocks array updates |
| supply_low_i | input | 1 | Supervisor flag, high blocks array updates |

## Verification
The checker watches several rules on every clock. `sda_oe` moves only while the synchronized SCL is low. A commit happens only on a stop, and never while protect or supply-low is active. A busy window always follows a commit, and the address-acknowledge state is never entered during one. Page writes never alter the upper pointer bits. Memory contents are left to the bench scenarios: page wrap and slot overwrite, read wrap across 255, discard on repeated start, address mismatch and the end of the busy window.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } eep_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [7:0] first_byte, input logic [6:0] own);
        return first_byte[7:1] == own;
    endfunction

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync
    import eep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [2:0] scl_sh;
    logic [2:0] sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= 3'b111;
            sda_sh <= 3'b111;
        end else begin
            scl_sh <= {scl_sh[1:0], scl_i};
            sda_sh <= {sda_sh[1:0], sda_i};
        end
    end

    always_comb begin
        evt.scl      = scl_sh[1];
        evt.sda      = sda_sh[1];
        evt.scl_rise = scl_sh[1] & ~scl_sh[2];
        evt.scl_fall = ~scl_sh[1] & scl_sh[2];
        evt.start    = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
        evt.stop     = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
    end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    buf_we,
    input  logic                                    buf_clr,
    input  logic [$clog2(PAGE_BYTES)-1:0]           buf_idx,
    input  logic [7:0]                              buf_data,
    input  logic                                    commit,
    input  logic [$clog2(MEM_BYTES)-1:0]            page_addr,
    input  logic [$clog2(MEM_BYTES)-1:0]            rd_addr,
    output logic [7:0]                              rd_data
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [7:0]            mem  [MEM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pval;

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    always_ff @(posedge clk) begin
        if (rst || buf_clr) pval <= '0;
        else if (buf_we) pval[buf_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (pval[i]) mem[{page_addr[AW-1:PW], PW'(i)}] <= pbuf[i];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
    parameter int BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)        left <= '0;
        else if (start) left <= CW'(BUSY_CYCLES);
        else if (busy)  left <= left - 1'b1;
    end

    assign busy = (left != '0);
endmodule

// File: rtl/i2c_page_eeprom.sv
module i2c_page_eeprom
    import eep_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         MEM_BYTES   = 256,
    parameter int         PAGE_BYTES  = 16,
    parameter int         BUSY_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic wp_i,
    input  logic supply_low_i
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    bus_evt_t   evt;
    eep_state_e state;
    logic [3:0] bitn;
    logic [7:0] shreg;
    logic [AW-1:0] addr;
    logic       rw;
    logic       mack;
    logic       pend;
    logic       busy;
    logic       buf_we;
    logic       commit;
    logic       wr_ok;
    logic [7:0] rd_data;
    logic       scl_s, start_s, stop_s;

    eep_bus_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    assign scl_s   = evt.scl;
    assign start_s = evt.start;
    assign stop_s  = evt.stop;

    assign wr_ok  = !wp_i && !supply_low_i;
    assign commit = evt.stop && pend && wr_ok;
    assign buf_we = (state == ST_WDAT) && evt.scl_fall && (bitn == 4'd8)
                    && !evt.start && !evt.stop;

    eep_store #(
        .MEM_BYTES  (MEM_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .buf_we    (buf_we),
        .buf_clr   (evt.start || evt.stop),
        .buf_idx   (addr[PW-1:0]),
        .buf_data  (shreg),
        .commit    (commit),
        .page_addr (addr),
        .rd_addr   (addr),
        .rd_data   (rd_data)
    );

    eep_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (commit),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bitn   <= '0;
            shreg  <= '0;
            addr   <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            pend   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (evt.start) begin
            state  <= ST_DEV;
            bitn   <= '0;
            pend   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            pend   <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (evt.scl_rise && bitn != 4'd8) begin
                        shreg <= {shreg[6:0], evt.sda};
                        bitn  <= bitn + 1'b1;
                    end else if (evt.scl_fall && bitn == 4'd8) begin
                        if (state == ST_DEV) begin
                            if (addr_hit(shreg, DEV_ADDR) && !busy) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_DEV_ACK;
                            end else begin
                                state  <= ST_SKIP;
                            end
                        end else if (state == ST_WADR) begin
                            sda_oe <= 1'b1;
                            addr   <= shreg[AW-1:0];
                            state  <= ST_WADR_ACK;
                        end else begin
                            sda_oe <= 1'b1;
                            addr   <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
                            pend   <= 1'b1;
                            state  <= ST_WDAT_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (evt.scl_fall) begin
                        bitn <= '0;
                        if (rw) begin
                            sda_oe <= ~rd_data[7];
                            state  <= ST_RDAT;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WADR;
                        end
                    end
                end
                ST_WADR_ACK, ST_WDAT_ACK: begin
                    if (evt.scl_fall) begin
                        sda_oe <= 1'b0;
                        bitn   <= '0;
                        state  <= ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (evt.scl_rise && bitn != 4'd8) begin
                        bitn <= bitn + 1'b1;
                    end else if (evt.scl_fall) begin
                        if (bitn == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe <= ~rd_data[3'(4'd7 - bitn)];
                        end
                    end
                end
                ST_RACK: begin
                    if (evt.scl_rise) begin
                        mack <= ~evt.sda;
                        if (!evt.sda) addr <= addr + 1'b1;
                    end else if (evt.scl_fall) begin
                        if (mack) begin
                            bitn   <= '0;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_RDAT;
                        end else begin
                            state  <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eep_checker.sv
module eep_checker
    import eep_pkg::*;
#(
    parameter int AW = 8,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_s,
    input logic          stop_s,
    input logic          sda_oe,
    input logic          wp_i,
    input logic          supply_low_i,
    input logic          commit,
    input logic          busy,
    input logic          buf_we,
    input logic [AW-1:0] addr,
    input eep_state_e    state
);
    // R10: open-drain drive moves only while SCL is low
    assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    // R4: the array is updated only on a stop condition
    assert_commit_on_stop_R4: assert property (@(posedge clk) disable iff (rst)
        commit |-> stop_s);

    assert_protect_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        wp_i |-> !commit);

    assert_supply_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        supply_low_i |-> !commit);

    // R7: no address acknowledge while programming
    assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> state != ST_DEV_ACK);

    assert_busy_follows_R7: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy);

    // R3: page writes keep the upper pointer bits
    assert_page_fixed_R3: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> addr[AW-1:PW] == $past(addr[AW-1:PW]));
endmodule

bind i2c_page_eeprom eep_checker #(
    .AW (AW),
    .PW (PW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_s        (scl_s),
    .stop_s       (stop_s),
    .sda_oe       (sda_oe),
    .wp_i         (wp_i),
    .supply_low_i (supply_low_i),
    .commit       (commit),
    .busy         (busy),
    .buf_we       (buf_we),
    .addr         (addr),
    .state        (state)
);

// File: tb/tb_i2c_page_eeprom.sv
module tb_i2c_page_eeprom;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         BUSY = 300;
    localparam int         Q    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic slow = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   n_tests = 0;
    int   n_fail  = 0;
    int   viol    = 0;
    logic prev_oe = 1'b0;
    logic done    = 1'b0;
    logic [7:0] rd [0:19];

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2c_page_eeprom #(
        .DEV_ADDR    (DEV),
        .MEM_BYTES   (256),
        .PAGE_BYTES  (16),
        .BUSY_CYCLES (BUSY)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe       (sda_oe),
        .wp_i         (wp),
        .supply_low_i (slow)
    );

    // SDA drive may only move while the bus clock is low (R10)
    always @(negedge clk) begin
        if (!rst && scl_m && (sda_oe !== prev_oe)) viol++;
        prev_oe = sda_oe;
    end

    // a 25-bit vector: {protect, word address, data written, value expected on readback}
    localparam logic [24:0] VEC [8] = '{
        {1'b0, 8'h00, 8'h5A, 8'h5A},
        {1'b0, 8'hFF, 8'hC3, 8'hC3},
        {1'b0, 8'h37, 8'h01, 8'h01},
        {1'b1, 8'h37, 8'hEE, 8'h01},
        {1'b0, 8'h80, 8'hFF, 8'hFF},
        {1'b1, 8'h90, 8'h12, 8'h00},
        {1'b0, 8'h37, 8'h80, 8'h80},
        {1'b0, 8'h6C, 8'hA5, 8'hA5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b0; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            d[i] = sda_line; wq(Q);
            scl_m = 1'b0;
        end
        wq(Q);
        sda_m = ~give_ack; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic write1(input logic [7:0] a, input logic [7:0] d, output logic dack);
        logic k;
        bstart();
        wbyte({DEV, 1'b0}, k);
        wbyte(a, k);
        wbyte(d, dack);
        bstop();
    endtask

    task automatic read_seq(input logic [7:0] a, input int n);
        logic k;
        logic [7:0] v;
        bstart();
        wbyte({DEV, 1'b0}, k);
        wbyte(a, k);
        bstart();
        wbyte({DEV, 1'b1}, k);
        for (int j = 0; j < n; j++) begin
            rbyte(j != n - 1, v);
            rd[j] = v;
        end
        bstop();
    endtask

    task automatic probe(output logic ack);
        bstart();
        wbyte({DEV, 1'b0}, ack);
        bstop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        wq(10);
        rst = 1'b0;
        wq(10);
        // R11: reset leaves SDA released and the array cleared
        chk("R11 reset sda_oe", sda_oe, 0);
        read_seq(8'h00, 1);
        chk("R11 reset array", rd[0], 8'h00);

        // vector table: byte write, optional protect, readback via dummy write (R2, R5, R9)
        foreach (VEC[v]) begin
            wp = VEC[v][24];
            write1(VEC[v][23:16], VEC[v][15:8], a);
            chk("R5 data byte acknowledged", a, 1);
            wp = 1'b0;
            wq(BUSY + 50);
            read_seq(VEC[v][23:16], 1);
            chk(VEC[v][24] ? "R5 protected readback" : "R2 R9 readback", rd[0], VEC[v][7:0]);
        end

        // R1: foreign address gets no acknowledge, own address does
        bstart();
        wbyte({7'h51, 1'b0}, a);
        bstop();
        chk("R1 foreign address", a, 0);
        probe(a);
        chk("R1 own address", a, 1);

        // R7: busy window after a committed write
        write1(8'h10, 8'h77, a);
        probe(a);
        chk("R7 nack while busy", a, 0);
        wq(BUSY + 50);
        probe(a);
        chk("R7 ack after window", a, 1);
        wq(BUSY + 50);
        read_seq(8'h10, 1);
        chk("R7 data after window", rd[0], 8'h77);

        // R3: 18-byte page write starting at 0x2E wraps inside page 0x20
        bstart();
        wbyte({DEV, 1'b0}, a);
        wbyte(8'h2E, a);
        for (int i = 0; i < 18; i++) wbyte(8'h40 + 8'(i), a);
        bstop();
        wq(BUSY + 50);
        read_seq(8'h20, 17);
        for (int k = 0; k < 16; k++) begin
            int i;
            i = (k + 2) % 16;
            if (i < 2) i += 16;
            chk("R3 page slot", rd[k], 8'h40 + 8'(i));
        end
        chk("R3 next page untouched", rd[16], 8'h00);

        // R8: sequential read wraps from 255 to 0
        read_seq(8'hFE, 4);
        chk("R8 byte FE", rd[0], 8'h00);
        chk("R8 byte FF", rd[1], 8'hC3);
        chk("R8 wrap to 00", rd[2], 8'h5A);
        chk("R8 byte 01", rd[3], 8'h00);

        // R4: repeated start discards buffered data and starts no busy window
        bstart();
        wbyte({DEV, 1'b0}, a);
        wbyte(8'h50, a);
        wbyte(8'h99, a);
        bstart();
        wbyte({DEV, 1'b0}, a);
        bstop();
        probe(a);
        chk("R4 no busy after discard", a, 1);
        read_seq(8'h50, 1);
        chk("R4 discarded data", rd[0], 8'h00);

        // R5: protected write starts no busy window
        wp = 1'b1;
        write1(8'h51, 8'h33, a);
        probe(a);
        wp = 1'b0;
        chk("R5 no busy when protected", a, 1);

        // R6: supply-low inhibit
        slow = 1'b1;
        write1(8'h60, 8'h3C, a);
        chk("R6 data byte acknowledged", a, 1);
        probe(a);
        slow = 1'b0;
        chk("R6 no busy when supply low", a, 1);
        read_seq(8'h60, 1);
        chk("R6 array unchanged", rd[0], 8'h00);

        // R11: reset during a transfer
        bstart();
        wbyte({DEV, 1'b0}, a);
        wbyte(8'h00, a);
        rst = 1'b1;
        wq(4);
        scl_m = 1'b1;
        sda_m = 1'b1;
        wq(4);
        rst = 1'b0;
        wq(4);
        chk("R11 sda released after reset", sda_oe, 0);
        read_seq(8'h00, 1);
        chk("R11 array cleared", rd[0], 8'h00);

        chk("R10 drive changed only while SCL low", viol, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule